// File: doc/BRIEF.md
# Not-Recently-Used Replacement Tracker

This block holds the replacement state of a 24-way set-associative cache with 2048 sets. Every set keeps one usage flag per way. When the cache hits a line or fills a line into a way, it reports that way on the access port, and the way's flag is raised. When the flag vector of a set would otherwise become all ones, the other flags of the set are dropped, so only the way just touched stays marked.

When the cache needs a line to evict, it presents a set index on the query port. One cycle later the block returns the lowest-numbered way of that set whose flag is still low. A query and an access in the same cycle see the state as it stood before that cycle's update.

Tags, hit detection and the data arrays belong to the surrounding cache. A line fill is reported as an ordinary access to the filled way.

Top module: `nru_tracker`

## Requirements
- R1: Reset clears every usage flag in every set. A query after reset returns way 0 for any set, and `vicValid` is low while reset is applied and in the cycle after.
- R2: An access with `accValid` high and a way index below 24 raises that way's flag in set `accSet` and changes no other set.
- R3: If raising the flag would leave all 24 flags of the set high, every flag of that set except the accessed way's is cleared instead.
- R4: The victim is the lowest-numbered way whose flag is low. It is reported on `vicWay` as a plain binary way number from 0 to 23.
- R5: `vicValid` is high in exactly the cycles that follow a cycle with `qryValid` high. `vicWay` then holds the victim of the set that was queried.
- R6: When an access and a query fall in the same cycle, the victim is computed from the state before that access takes effect.
- R7: An access whose way index is 24 or higher (codes 24 to 31 of the 5-bit field) has no effect on any set.
- R8: A way accessed in one cycle is never the victim of a query to the same set in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| accValid | input | 1 | An access (hit or fill) is reported this cycle |
| accSet | input | 11 | Set index of the access |
| accWay | input | 5 | Way index of the access |
| qryValid | input | 1 | A victim query is made this cycle |
| qrySet | input | 11 | Set index of the query |
| vicValid | output | 1 | `vicWay` holds the answer to the previous cycle's query |
| vicWay | output | 5 | Way selected for replacement |

## Verification
The bench builds the block with its default sizes of 24 ways and 2048 sets. A reference model of all 2048 usage vectors is therefore small enough to keep in the bench. With 24 ways, saturation is reached after 24 distinct accesses, so several saturation orders fit in one short run. The first and last set indices, 0 and 2047, can be addressed directly. The 5-bit way field also carries the unused codes 24 to 31, which lets the bench drive those codes and confirm that they are ignored.

// File: rtl/nru_pkg.sv
package nru_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic wrEn;         // write the updated usage row of the accessed set
    logic clearOthers;  // saturation: keep only the accessed way's flag
    logic capture;      // register a victim for the queried set
  } nru_strobe_t;

endpackage

// File: rtl/nru_victim_enc.sv
// Picks the lowest-numbered way whose usage flag is low.
module nru_victim_enc #(
  parameter int NUM_WAYS = 24,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] usageRow,
  output logic [WAY_W-1:0]    victim
);

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!found && !usageRow[i]) begin
        victim = WAY_W'(i);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/nru_ctrl.sv
// Turns the port requests into datapath strobes.
module nru_ctrl
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 24,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             rstN,
  input  logic             accValid,
  input  logic [WAY_W-1:0] accWay,
  input  logic             qryValid,
  input  logic             othersFull,
  output nru_strobe_t      strobe
);

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  logic wayInRange;

  assign wayInRange = (accWay <= LAST_WAY);

  always_comb begin
    strobe             = '0;
    strobe.wrEn        = rstN && accValid && wayInRange;
    strobe.clearOthers = othersFull;
    strobe.capture     = qryValid;
  end

endmodule

// File: rtl/nru_datapath.sv
// Usage-flag storage, row update and registered victim.
module nru_datapath
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 24,
  parameter int NUM_SETS = 2048,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  nru_strobe_t      strobe,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  input  logic [SET_W-1:0] qrySet,
  output logic             othersFull,
  output logic             vicValid,
  output logic [WAY_W-1:0] vicWay
);

  // Storage has no reset; a per-set live flag marks rows written since reset.
  logic [NUM_WAYS-1:0] usageMem [NUM_SETS];
  logic [NUM_SETS-1:0] rowLive;

  logic [NUM_WAYS-1:0] accRow;
  logic [NUM_WAYS-1:0] wayMask;
  logic [NUM_WAYS-1:0] nextRow;
  logic [NUM_WAYS-1:0] qryRow;
  logic [WAY_W-1:0]    qryVictim;

  genvar g;
  generate
    for (g = 0; g < NUM_WAYS; g++) begin : gen_mask
      assign wayMask[g] = (accWay == WAY_W'(g));
    end
  endgenerate

  assign accRow     = rowLive[accSet] ? usageMem[accSet] : '0;
  assign othersFull = &(accRow | wayMask);
  assign nextRow    = strobe.clearOthers ? wayMask : (accRow | wayMask);
  assign qryRow     = rowLive[qrySet] ? usageMem[qrySet] : '0;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      usageMem[accSet] <= nextRow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowLive <= '0;
    end else if (strobe.wrEn) begin
      rowLive[accSet] <= 1'b1;
    end
  end

  nru_victim_enc #(
    .NUM_WAYS (NUM_WAYS)
  ) u_enc (
    .usageRow (qryRow),
    .victim   (qryVictim)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vicValid <= 1'b0;
      vicWay   <= '0;
    end else begin
      vicValid <= strobe.capture;
      if (strobe.capture) begin
        vicWay <= qryVictim;
      end
    end
  end

endmodule

// File: rtl/nru_tracker.sv
// Thin top: control plus datapath.
module nru_tracker
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 24,
  parameter int NUM_SETS = 2048,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  input  logic             qryValid,
  input  logic [SET_W-1:0] qrySet,
  output logic             vicValid,
  output logic [WAY_W-1:0] vicWay
);

  nru_strobe_t strobe;
  logic        othersFull;

  nru_ctrl #(
    .NUM_WAYS (NUM_WAYS)
  ) u_ctrl (
    .rstN       (rstN),
    .accValid   (accValid),
    .accWay     (accWay),
    .qryValid   (qryValid),
    .othersFull (othersFull),
    .strobe     (strobe)
  );

  nru_datapath #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .accSet     (accSet),
    .accWay     (accWay),
    .qrySet     (qrySet),
    .othersFull (othersFull),
    .vicValid   (vicValid),
    .vicWay     (vicWay)
  );

endmodule

// File: rtl/nru_tracker_chk.sv
module nru_tracker_chk #(
  parameter int NUM_WAYS = 24,
  parameter int NUM_SETS = 2048,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             accValid,
  input logic [SET_W-1:0] accSet,
  input logic [WAY_W-1:0] accWay,
  input logic             qryValid,
  input logic [SET_W-1:0] qrySet,
  input logic             vicValid,
  input logic [WAY_W-1:0] vicWay
);

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !vicValid);

  assert_valid_after_query_R5: assert property (@(posedge clk) disable iff (!rstN)
    qryValid |=> vicValid);

  assert_idle_without_query_R5: assert property (@(posedge clk) disable iff (!rstN)
    !qryValid |=> !vicValid);

  assert_victim_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    vicValid |-> (vicWay <= LAST_WAY));

  assert_recent_not_victim_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(accValid) && ($past(accWay) <= LAST_WAY)
      && qryValid && (qrySet == $past(accSet)))
    |=> (vicWay != $past(accWay, 2)));

endmodule

bind nru_tracker nru_tracker_chk #(
  .NUM_WAYS (NUM_WAYS),
  .NUM_SETS (NUM_SETS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .accSet   (accSet),
  .accWay   (accWay),
  .qryValid (qryValid),
  .qrySet   (qrySet),
  .vicValid (vicValid),
  .vicWay   (vicWay)
);

// File: tb/nru_tracker_tb.sv
`timescale 1ns/1ps
module nru_tracker_tb;

  localparam int WAYS  = 24;
  localparam int SETS  = 2048;
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             accValid = 1'b0;
  logic [SET_W-1:0] accSet = '0;
  logic [WAY_W-1:0] accWay = '0;
  logic             qryValid = 1'b0;
  logic [SET_W-1:0] qrySet = '0;
  logic             vicValid;
  logic [WAY_W-1:0] vicWay;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [WAYS-1:0] mdl [SETS];

  always #10 clk = ~clk;

  nru_tracker #(.NUM_WAYS(WAYS), .NUM_SETS(SETS)) u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet), .accWay(accWay),
    .qryValid(qryValid), .qrySet(qrySet), .vicValid(vicValid), .vicWay(vicWay)
  );

  function automatic int mdlVictim(input int s);
    for (int i = 0; i < WAYS; i++) begin
      if (!mdl[s][i]) return i;
    end
    return 0;
  endfunction

  function automatic void mdlTouch(input int s, input int w);
    logic [WAYS-1:0] r;
    r = mdl[s];
    r[w] = 1'b1;
    if (&r) begin
      r = '0;
      r[w] = 1'b1;
    end
    mdl[s] = r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; called at a falling edge, returns at the next one.
  task automatic step(input bit aV, input int aS, input int aW,
                      input bit qV, input int qS, input string tag);
    int expWay;
    expWay   = mdlVictim(qS);
    accValid = aV;
    accSet   = aS[SET_W-1:0];
    accWay   = aW[WAY_W-1:0];
    qryValid = qV;
    qrySet   = qS[SET_W-1:0];
    @(posedge clk);
    if (aV && aW < WAYS) mdlTouch(aS, aW);
    @(negedge clk);
    accValid = 1'b0;
    qryValid = 1'b0;
    check(vicValid == qV, {tag, " R5 valid"}, int'(vicValid), int'(qV));
    if (qV) check(int'(vicWay) == expWay, {tag, " way"}, int'(vicWay), expWay);
  endtask

  task automatic touch(input int s, input int w);
    step(1'b1, s, w, 1'b0, 0, "touch");
  endtask

  task automatic query(input int s, input string tag);
    step(1'b0, 0, 0, 1'b1, s, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(vicValid == 1'b0, "R1 valid low in reset", int'(vicValid), 0);
    rstN = 1'b1;
    for (int s = 0; s < SETS; s++) mdl[s] = '0;
  endtask

  task automatic testReset();
    doReset();
    query(0, "R1 set 0 first victim");
    query(SETS - 1, "R1 last set first victim");
    query(700, "R1 mid set first victim");
    step(1'b0, 0, 0, 1'b0, 0, "R5 no query");
  endtask

  task automatic testFillOrder();
    for (int w = 0; w < 6; w++) touch(3, w);
    query(3, "R2 R4 after ways 0..5");
    query(4, "R2 neighbour set untouched");
    query(2, "R2 lower neighbour untouched");
    touch(9, 2);
    touch(9, 0);
    query(9, "R4 lowest zero is way 1");
    touch(9, 0);
    query(9, "R2 repeated access stable");
  endtask

  task automatic testSaturation();
    for (int w = 0; w < WAYS; w++) touch(5, w);
    query(5, "R3 saturate on way 23");
    check(mdl[5] == 24'h80_0000, "R3 model row", int'(mdl[5]), 24'h80_0000);
    for (int w = 0; w < WAYS; w++) if (w != 7) touch(6, w);
    touch(6, 7);
    query(6, "R3 saturate on way 7");
    touch(6, 0);
    query(6, "R3 R4 after saturate then way 0");
    for (int w = WAYS - 1; w >= 0; w--) touch(SETS - 1, w);
    query(SETS - 1, "R3 descending fill saturates on way 0");
  endtask

  task automatic testSameCycle();
    touch(12, 0);
    step(1'b1, 12, 1, 1'b1, 12, "R6 same-cycle sees old state");
    query(12, "R6 update visible next cycle");
    step(1'b1, 13, 0, 1'b1, 13, "R8 R6 fresh set same cycle");
    query(13, "R8 recent way not victim");
  endtask

  task automatic testIgnoredWay();
    step(1'b1, 20, 25, 1'b0, 0, "R7 way 25");
    query(20, "R7 way 25 ignored");
    touch(21, 0);
    step(1'b1, 21, 31, 1'b0, 0, "R7 way 31");
    query(21, "R7 way 31 ignored");
    step(1'b1, 21, 24, 1'b1, 21, "R7 way 24 with query");
    query(21, "R7 way 24 ignored");
  endtask

  task automatic testResetAgain();
    doReset();
    query(3, "R1 reset clears used set");
    query(5, "R1 reset clears saturated set");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) mdl[s] = '0;
    testReset();
    testFillOrder();
    testSaturation();
    testSameCycle();
    testIgnoredWay();
    testResetAgain();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule